// File: doc/BRIEF.md
# Translation Lookaside Unit with Access Checking

This block converts virtual addresses into physical addresses for the cache side of a core. A small, fully associative table of recent translations is searched first. Each entry holds a virtual page number, a physical page number, read/write/execute rights and a user-accessible flag. On a match the rights are checked against the kind of access and the privilege of the requester. On a miss the block asks an external page-table walker for the mapping. If the page is in memory, the answer is installed in the table and the lookup runs again. If the page is absent, the access ends with a page-fault result.

Every translation ends in exactly one response: success with a physical address, a page fault, or a protection fault. The response always returns the original virtual address, so the faulting access can be restarted later. The low 12 bits of the address are the page offset and pass through unchanged. Only one translation is in flight at a time.

All four data interfaces use valid/ready handshakes:
- A transfer happens on a rising edge where both valid and ready are high.
- A source that has raised valid keeps it high, and keeps its payload unchanged, until the transfer.
- The request port drops ready from the cycle after a request is accepted until that request's response has been taken.
- A consumer that holds `rsp_ready` low stalls the block without any loss of data.

Top module: `xlate_tlb`

## Requirements
- R1: After reset, `req_ready` is high and `rsp_valid` and `walk_req_valid` are low; the table holds no valid entries.
- R2: For an access that matches an entry and is permitted, the response has status 0 (ok) and `rsp_paddr` = {entry PPN, request offset[11:0]}. No walk is issued.
- R3: A miss raises `walk_req_valid` with `walk_req_vpn` equal to `req_vaddr[31:12]`. `req_ready` stays low while the walk is outstanding.
- R4: A walk response with `walk_rsp_resident`=1 installs the mapping, and the access then completes as a hit. Later accesses to the same page issue no walk while the entry remains.
- R5: A walk response with `walk_rsp_resident`=0 yields status 1 (page fault) and installs nothing. A repeat access to that page walks again.
- R6: The rights field is bit0 read, bit1 write, bit2 execute and bit3 user. Access kind 0 (load) needs read, kind 1 (store) needs write and kind 2 (fetch) needs execute. A missing right yields status 2 (protection fault) with `rsp_paddr` = 0.
- R7: An access with `req_user`=1 to an entry whose user bit is 0 yields status 2. An access with `req_user`=0 ignores the user bit.
- R8: The table has 8 entries, and refills take victims in round-robin order starting from slot 0. The ninth distinct resident page evicts the first page installed.
- R9: While `rsp_valid` is high and `rsp_ready` is low, the response holds steady. While `walk_req_valid` is high and `walk_req_ready` is low, the walk request holds steady.
- R10: Every response, faulting or not, carries the request's virtual address on `rsp_vaddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| req_user | input | 1 | 1 for a user-mode access |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_status | output | 2 | 0 ok, 1 page fault, 2 protection fault |
| rsp_paddr | output | 30 | Physical address (0 on a fault) |
| rsp_vaddr | output | 32 | Virtual address of the answered request |
| walk_req_valid | output | 1 | Walk request present |
| walk_req_ready | input | 1 | Walker accepts the request |
| walk_req_vpn | output | 20 | Page number to walk |
| walk_rsp_valid | input | 1 | Walk result present |
| walk_rsp_ready | output | 1 | Block takes the walk result |
| walk_rsp_resident | input | 1 | Page is in memory |
| walk_rsp_ppn | input | 18 | Physical page number |
| walk_rsp_perm | input | 4 | Rights, bit order as in R6 |

## Verification
Some properties are checked by assertions on every cycle:
- at most one entry matches any page;
- a refill is followed at once by a hit;
- a successful response keeps the request's offset;
- both output handshakes hold steady under back-pressure;
- the request port stays closed while a walk result is taken.

Other behaviour can only be shown by the bench's scenarios. This covers the actual rights decisions for each kind and privilege, the difference between page and protection faults, and the round-robin victim order with its later re-walks. For these the bench keeps its own model of the table and page table, and compares each response and the number of walks.

// File: rtl/xlate_tlb_pkg.sv
package xlate_tlb_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_kind_e;

  typedef enum logic [1:0] {
    XS_OK    = 2'd0,
    XS_PAGE  = 2'd1,
    XS_PROT  = 2'd2
  } xs_status_e;

  typedef struct packed {
    logic usr;
    logic ex;
    logic wr;
    logic rd;
  } rights_t;

endpackage

// File: rtl/xlate_tlb_cam.sv
module xlate_tlb_cam
  import xlate_tlb_pkg::*;
#(
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 18,
  parameter int ENTRIES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  output rights_t          lk_rights,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  rights_t          fill_rights
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] slot_vld;
  logic [VPN_W-1:0]   slot_vpn [ENTRIES];
  logic [PPN_W-1:0]   slot_ppn [ENTRIES];
  rights_t            slot_rights [ENTRIES];
  logic [IDX_W-1:0]   victim;
  logic [ENTRIES-1:0] match_vec;

  // Storage and round-robin victim pointer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_vld <= '0;
      victim   <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        slot_vpn[i]    <= '0;
        slot_ppn[i]    <= '0;
        slot_rights[i] <= '0;
      end
    end else if (fill_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (victim == IDX_W'(i)) begin
          slot_vld[i]    <= 1'b1;
          slot_vpn[i]    <= fill_vpn;
          slot_ppn[i]    <= fill_ppn;
          slot_rights[i] <= fill_rights;
        end
      end
      victim <= (victim == LAST_IDX) ? '0 : victim + 1'b1;
    end
  end

  // Parallel tag compare, one comparator per slot
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = slot_vld[g] && (slot_vpn[g] == lk_vpn);
  end

  always_comb begin
    lk_ppn    = '0;
    lk_rights = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) begin
        lk_ppn    = lk_ppn | slot_ppn[i];
        lk_rights = lk_rights | slot_rights[i];
      end
    end
  end

  assign lk_hit = |match_vec;

  // R8: a page never sits in two slots
  a_r8_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  // R4: refills happen only for pages that are absent
  a_r4_fill_only_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && fill_vpn == lk_vpn) |-> !lk_hit);

endmodule

// File: rtl/xlate_tlb_rights.sv
module xlate_tlb_rights
  import xlate_tlb_pkg::*;
(
  input  acc_kind_e kind,
  input  logic      user,
  input  rights_t   rights,
  output logic      allow
);
  logic kind_ok;

  always_comb begin
    unique case (kind)
      ACC_LOAD:  kind_ok = rights.rd;
      ACC_STORE: kind_ok = rights.wr;
      ACC_FETCH: kind_ok = rights.ex;
      default:   kind_ok = 1'b0;
    endcase
    allow = kind_ok && !(user && !rights.usr);
  end

endmodule

// File: rtl/xlate_tlb_ctrl.sv
module xlate_tlb_ctrl
  import xlate_tlb_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 30,
  parameter int OFF_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [VA_W-1:0]       req_vaddr,
  input  logic [1:0]            req_kind,
  input  logic                  req_user,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [1:0]            rsp_status,
  output logic [PA_W-1:0]       rsp_paddr,
  output logic [VA_W-1:0]       rsp_vaddr,
  output logic                  walk_req_valid,
  input  logic                  walk_req_ready,
  output logic [VA_W-OFF_W-1:0] walk_req_vpn,
  input  logic                  walk_rsp_valid,
  output logic                  walk_rsp_ready,
  input  logic                  walk_rsp_resident,
  output logic [VA_W-OFF_W-1:0] lk_vpn,
  input  logic                  lk_hit,
  input  logic [PA_W-OFF_W-1:0] lk_ppn,
  output logic                  fill_en,
  output acc_kind_e             chk_kind,
  output logic                  chk_user,
  input  logic                  chk_allow
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOK, ST_WREQ, ST_WRSP, ST_RESP
  } st_e;

  st_e              state;
  logic [VA_W-1:0]  cur_va;
  acc_kind_e        cur_kind;
  logic             cur_user;
  xs_status_e       out_status;
  logic [PA_W-1:0]  out_paddr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cur_va     <= '0;
      cur_kind   <= ACC_LOAD;
      cur_user   <= 1'b0;
      out_status <= XS_OK;
      out_paddr  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          cur_va   <= req_vaddr;
          cur_kind <= acc_kind_e'(req_kind);
          cur_user <= req_user;
          state    <= ST_LOOK;
        end
        ST_LOOK: if (lk_hit) begin
          out_status <= chk_allow ? XS_OK : XS_PROT;
          out_paddr  <= chk_allow ? {lk_ppn, cur_va[OFF_W-1:0]} : '0;
          state      <= ST_RESP;
        end else begin
          state <= ST_WREQ;
        end
        ST_WREQ: if (walk_req_ready) state <= ST_WRSP;
        ST_WRSP: if (walk_rsp_valid) begin
          if (walk_rsp_resident) begin
            state <= ST_LOOK;
          end else begin
            out_status <= XS_PAGE;
            out_paddr  <= '0;
            state      <= ST_RESP;
          end
        end
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready      = (state == ST_IDLE);
  assign rsp_valid      = (state == ST_RESP);
  assign rsp_status     = out_status;
  assign rsp_paddr      = out_paddr;
  assign rsp_vaddr      = cur_va;
  assign lk_vpn         = cur_va[VA_W-1:OFF_W];
  assign walk_req_valid = (state == ST_WREQ);
  assign walk_req_vpn   = cur_va[VA_W-1:OFF_W];
  assign walk_rsp_ready = (state == ST_WRSP);
  assign fill_en        = (state == ST_WRSP) && walk_rsp_valid && walk_rsp_resident;
  assign chk_kind       = cur_kind;
  assign chk_user       = cur_user;

  // R9: response holds under back-pressure
  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr)
      && $stable(rsp_status) && $stable(rsp_vaddr)));

  // R9: walk request holds until taken
  a_r9_walk_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req_valid && !walk_req_ready) |=> (walk_req_valid && $stable(walk_req_vpn)));

  // R3: no new request accepted while a walk result is taken
  a_r3_closed_during_walk: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_rsp_valid && walk_rsp_ready) |-> !req_ready);

  // R4: the cycle after a refill the page is found in the table
  a_r4_refill_then_hit: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> lk_hit);

  // R2: a successful response keeps the page offset
  a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 2'd0) |->
      (rsp_paddr[OFF_W-1:0] == rsp_vaddr[OFF_W-1:0]));

endmodule

// File: rtl/xlate_tlb.sv
module xlate_tlb
  import xlate_tlb_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 30,
  parameter int OFF_W   = 12,
  parameter int ENTRIES = 8,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PPN_W  = PA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_kind,
  input  logic             req_user,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [1:0]       rsp_status,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [VA_W-1:0]  rsp_vaddr,
  output logic             walk_req_valid,
  input  logic             walk_req_ready,
  output logic [VPN_W-1:0] walk_req_vpn,
  input  logic             walk_rsp_valid,
  output logic             walk_rsp_ready,
  input  logic             walk_rsp_resident,
  input  logic [PPN_W-1:0] walk_rsp_ppn,
  input  logic [3:0]       walk_rsp_perm
);
  logic [VPN_W-1:0] lk_vpn;
  logic             lk_hit;
  logic [PPN_W-1:0] lk_ppn;
  rights_t          lk_rights;
  logic             fill_en;
  acc_kind_e        chk_kind;
  logic             chk_user;
  logic             chk_allow;

  xlate_tlb_ctrl #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_ctrl (
    .clk               (clk),
    .rst_n             (rst_n),
    .req_valid         (req_valid),
    .req_ready         (req_ready),
    .req_vaddr         (req_vaddr),
    .req_kind          (req_kind),
    .req_user          (req_user),
    .rsp_valid         (rsp_valid),
    .rsp_ready         (rsp_ready),
    .rsp_status        (rsp_status),
    .rsp_paddr         (rsp_paddr),
    .rsp_vaddr         (rsp_vaddr),
    .walk_req_valid    (walk_req_valid),
    .walk_req_ready    (walk_req_ready),
    .walk_req_vpn      (walk_req_vpn),
    .walk_rsp_valid    (walk_rsp_valid),
    .walk_rsp_ready    (walk_rsp_ready),
    .walk_rsp_resident (walk_rsp_resident),
    .lk_vpn            (lk_vpn),
    .lk_hit            (lk_hit),
    .lk_ppn            (lk_ppn),
    .fill_en           (fill_en),
    .chk_kind          (chk_kind),
    .chk_user          (chk_user),
    .chk_allow         (chk_allow)
  );

  xlate_tlb_cam #(.VPN_W(VPN_W), .PPN_W(PPN_W), .ENTRIES(ENTRIES)) u_cam (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_vpn      (lk_vpn),
    .lk_hit      (lk_hit),
    .lk_ppn      (lk_ppn),
    .lk_rights   (lk_rights),
    .fill_en     (fill_en),
    .fill_vpn    (lk_vpn),
    .fill_ppn    (walk_rsp_ppn),
    .fill_rights (rights_t'(walk_rsp_perm))
  );

  xlate_tlb_rights u_rights (
    .kind   (chk_kind),
    .user   (chk_user),
    .rights (lk_rights),
    .allow  (chk_allow)
  );

endmodule

// File: tb/xlate_tlb_tb_top.sv
module xlate_tlb_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        req_user = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [1:0]  rsp_status;
  logic [29:0] rsp_paddr;
  logic [31:0] rsp_vaddr;
  logic        walk_req_valid;
  logic        walk_req_ready = 1'b0;
  logic [19:0] walk_req_vpn;
  logic        walk_rsp_valid = 1'b0;
  logic        walk_rsp_ready;
  logic        walk_rsp_resident = 1'b0;
  logic [17:0] walk_rsp_ppn = '0;
  logic [3:0]  walk_rsp_perm = '0;

  int checks = 0;
  int errors = 0;
  int walk_cnt = 0;
  int stub_stall = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xlate_tlb dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
    .rsp_paddr(rsp_paddr), .rsp_vaddr(rsp_vaddr),
    .walk_req_valid(walk_req_valid), .walk_req_ready(walk_req_ready),
    .walk_req_vpn(walk_req_vpn),
    .walk_rsp_valid(walk_rsp_valid), .walk_rsp_ready(walk_rsp_ready),
    .walk_rsp_resident(walk_rsp_resident), .walk_rsp_ppn(walk_rsp_ppn),
    .walk_rsp_perm(walk_rsp_perm)
  );

  // Page-table stub: low nibble F means absent, rights come from vpn[7:4]
  function automatic bit pt_res(input logic [19:0] v);
    return v[3:0] != 4'hF;
  endfunction
  function automatic logic [17:0] pt_ppn(input logic [19:0] v);
    return v[17:0] ^ 18'h2A5A5;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always begin
    @(negedge clk);
    if (walk_req_valid) begin
      for (int s = 0; s < stub_stall; s++) begin
        chk(req_ready == 1'b0, "R3 req_ready during walk", 64'(req_ready), 64'd0);
        @(negedge clk);
        chk(walk_req_valid == 1'b1, "R9 walk valid held", 64'(walk_req_valid), 64'd1);
      end
      walk_req_ready = 1'b1;
      @(negedge clk);
      walk_req_ready = 1'b0;
      walk_cnt++;
      walk_rsp_resident = pt_res(walk_req_vpn);
      walk_rsp_ppn      = pt_ppn(walk_req_vpn);
      walk_rsp_perm     = walk_req_vpn[7:4];
      walk_rsp_valid    = 1'b1;
      @(negedge clk);
      walk_rsp_valid = 1'b0;
    end
  end

  // Bench model of the table
  logic [19:0] m_vpn [8];
  bit          m_vld [8];
  int          m_ptr = 0;

  task automatic access(input logic [31:0] va, input logic [1:0] kind,
                        input bit user, input int hold);
    logic [19:0] vpn = va[31:12];
    bit hit = 1'b0;
    bit res;
    bit need;
    logic [3:0] pr = vpn[7:4];
    logic [1:0] exp_st;
    logic [29:0] exp_pa;
    int w0;
    int exp_w;
    logic [29:0] pa_snap;
    for (int i = 0; i < 8; i++) if (m_vld[i] && m_vpn[i] == vpn) hit = 1'b1;
    res = pt_res(vpn);
    exp_w = hit ? 0 : 1;
    if (!hit && res) begin
      m_vpn[m_ptr] = vpn; m_vld[m_ptr] = 1'b1; m_ptr = (m_ptr + 1) % 8;
    end
    need = (kind == 2'd0) ? pr[0] : (kind == 2'd1) ? pr[1] : (kind == 2'd2) ? pr[2] : 1'b0;
    if (!res) begin exp_st = 2'd1; exp_pa = '0; end
    else if (!need || (user && !pr[3])) begin exp_st = 2'd2; exp_pa = '0; end
    else begin exp_st = 2'd0; exp_pa = {pt_ppn(vpn), va[11:0]}; end

    w0 = walk_cnt;
    @(negedge clk);
    req_vaddr = va; req_kind = kind; req_user = user; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    chk(rsp_status == exp_st, "R2 R5 R6 R7 status", 64'(rsp_status), 64'(exp_st));
    chk(rsp_paddr == exp_pa, "R2 R6 paddr", 64'(rsp_paddr), 64'(exp_pa));
    chk(rsp_vaddr == va, "R10 vaddr returned", 64'(rsp_vaddr), 64'(va));
    chk(walk_cnt - w0 == exp_w, "R4 R5 R8 walk count", 64'(walk_cnt - w0), 64'(exp_w));
    pa_snap = rsp_paddr;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_paddr == pa_snap, "R9 rsp held", 64'(rsp_paddr), 64'(pa_snap));
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  typedef struct packed {
    logic [31:0] va;
    logic [1:0]  kind;
    logic        user;
  } vec_t;

  localparam vec_t [0:9] VECS = '{
    '{32'h000F1_123, 2'd0, 1'b1},  // R4 walk then ok
    '{32'h000F1_FFC, 2'd1, 1'b1},  // R2 hit store
    '{32'h00071_010, 2'd0, 1'b1},  // R7 user to supervisor page
    '{32'h00071_020, 2'd0, 1'b0},  // R7 supervisor ok
    '{32'h00011_000, 2'd1, 1'b0},  // R6 store to read-only
    '{32'h00011_004, 2'd0, 1'b0},  // R6 load ok
    '{32'h00031_008, 2'd2, 1'b0},  // R6 fetch without execute
    '{32'h000FF_100, 2'd0, 1'b0},  // R5 page fault
    '{32'h000FF_200, 2'd0, 1'b0},  // R5 walks again
    '{32'h00051_ABC, 2'd2, 1'b0}   // R6 fetch ok
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_vld[i] = 1'b0; m_vpn[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 req_ready", 64'(req_ready), 64'd1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk(walk_req_valid == 1'b0, "R1 walk_req_valid", 64'(walk_req_valid), 64'd0);

    foreach (VECS[k]) access(VECS[k].va, VECS[k].kind, VECS[k].user, 0);

    // R3 R9: walker stalls, request port stays closed
    stub_stall = 4;
    access(32'h000F2_00C, 2'd0, 1'b1, 0);
    stub_stall = 0;
    // R9: consumer back-pressure
    access(32'h000F2_0F0, 2'd1, 1'b0, 5);
    // R8: fill to 8 entries, then evict in round-robin order
    access(32'h000F3_000, 2'd0, 1'b0, 0);
    access(32'h000F4_000, 2'd0, 1'b0, 0);
    access(32'h000F5_000, 2'd0, 1'b0, 0);  // evicts slot 0 (F1)
    access(32'h000F1_000, 2'd0, 1'b0, 0);  // re-walk, evicts 71
    access(32'h00011_008, 2'd0, 1'b0, 0);  // still present
    access(32'h00071_000, 2'd0, 1'b0, 0);  // re-walk
    access(32'h000F5_444, 2'd2, 1'b1, 0);  // hit

    // R1: a fresh reset empties the table
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) m_vld[i] = 1'b0;
    m_ptr = 0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 req_ready after reset", 64'(req_ready), 64'd1);
    access(32'h00011_008, 2'd0, 1'b0, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule